// File: doc/BRIEF.md
# Banked Auxiliary Fault-Status Register Access Controller

This block holds one 32-bit auxiliary fault-status system register and carries out coprocessor move-to (write) and move-from (read) accesses to it. Each request carries the instruction's encoding fields, the current privilege level (0 to 3), flags that describe how levels 2 and 3 are configured, the hypervisor trap bits, the secure/non-secure select bit and write data. In the same cycle the block returns an outcome code and the read data.

An access at level 0 is an undefined instruction. An access at level 1 with level 2 enabled passes through a fixed chain of hypervisor trap checks. Reads and writes use different trap bits in this chain. If an access is not undefined and not trapped, it goes to one of three physical copies: a secure copy, a non-secure copy, or a single unbanked copy. The choice depends on the privilege level, on whether level 3 exists in 32-bit mode, and on the NS bit. A write takes effect at the next clock edge. All three copies reset to a parameter value, which is zero by default.

Top module: `auxfault_bank_reg`

## Requirements
- R1: A request is a hit only when cp=0xF, op1=0, crn=0x5, crm=0x1 and op2=1. For any other encoding, `hit` is 0, `outcome` is OK (0), `rdata` is 0, `syndrome` is 0 and no copy changes.
- R2: A hit at level 0 gives outcome UNDEF (1), for reads and for writes.
- R3: At level 1 with level 2 enabled, the first check is the group trap bit. This is `grp_trap32` when level 2 runs in 32-bit mode and `grp_trap64` otherwise. When the bit is set, the outcome is TRAP32 (3) in 32-bit mode or TRAP64 (2) otherwise, and `syndrome` is 0x03.
- R4: The second check uses the virtual-memory trap bit. Reads use `rd_trap32`/`rd_trap64` and writes use `wr_trap32`/`wr_trap64`, each picked by level 2's mode. The trap bits for the other direction, and for the other mode, have no effect.
- R5: When level 2 is not enabled, all trap bits are ignored at level 1.
- R6: At level 1 with no trap, the bank is secure when level 3 is present in 32-bit mode and NS=0. It is non-secure when level 3 is present in 32-bit mode and NS=1. In all other cases the unbanked copy is used.
- R7: At level 2, the non-secure copy is used when level 3 is present in 32-bit mode. Otherwise the unbanked copy is used. NS has no effect.
- R8: At level 3, NS=0 selects the secure copy and NS=1 selects the non-secure copy.
- R9: A write whose outcome is not OK leaves all three copies unchanged. `rdata` is 0 whenever the outcome is not OK. `syndrome` is 0 unless the outcome is a trap.
- R10: After reset, every copy reads RST_VAL (0). An OK write stores all 32 bits in the selected copy at the next rising edge. An OK read returns that copy in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| enc_cp | input | 4 | Coprocessor number |
| enc_op1 | input | 3 | First opcode field |
| enc_crn | input | 4 | Primary register field |
| enc_crm | input | 4 | Secondary register field |
| enc_op2 | input | 3 | Second opcode field |
| cur_lvl | input | 2 | Current privilege level |
| lvl2_en | input | 1 | Level 2 enabled |
| lvl2_is32 | input | 1 | Level 2 runs in 32-bit mode |
| lvl3_present | input | 1 | Level 3 implemented |
| lvl3_is32 | input | 1 | Level 3 runs in 32-bit mode |
| ns_bit | input | 1 | Non-secure select |
| grp_trap64 | input | 1 | Group trap bit, 64-bit-mode copy |
| grp_trap32 | input | 1 | Group trap bit, 32-bit-mode copy |
| rd_trap64 | input | 1 | Read VM trap, 64-bit-mode copy |
| rd_trap32 | input | 1 | Read VM trap, 32-bit-mode copy |
| wr_trap64 | input | 1 | Write VM trap, 64-bit-mode copy |
| wr_trap32 | input | 1 | Write VM trap, 32-bit-mode copy |
| wdata | input | 32 | Write data |
| hit | output | 1 | Request decodes to this register |
| outcome | output | 2 | 0 OK, 1 UNDEF, 2 TRAP64, 3 TRAP32 |
| syndrome | output | 6 | Trap syndrome class, valid on trap outcomes |
| rdata | output | 32 | Read data |

## Verification
The bench sets the read-trap bits while writing, and the write-trap bits while reading. A design that confuses the two directions would trap where it should not, or fail to trap where it should. The bench also covers these cases:
- Each trap bit is set with level 2 in the opposite mode, so a design that takes the wrong copy is caught.
- Level 2 accesses are made with NS set, which catches a design that routes them by NS.
- Faulting writes are followed by read-back of all three copies, which exposes any stray store.
- Encodings are made to differ from the hit encoding in a single field, which catches a partial decode.

// File: rtl/auxfault_bank_reg.sv
module auxfault_bank_reg #(
  parameter int          DW      = 32,
  parameter logic [DW-1:0] RST_VAL = '0,
  parameter logic [5:0]  TRAP_EC = 6'h03
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [3:0]    enc_cp,
  input  logic [2:0]    enc_op1,
  input  logic [3:0]    enc_crn,
  input  logic [3:0]    enc_crm,
  input  logic [2:0]    enc_op2,
  input  logic [1:0]    cur_lvl,
  input  logic          lvl2_en,
  input  logic          lvl2_is32,
  input  logic          lvl3_present,
  input  logic          lvl3_is32,
  input  logic          ns_bit,
  input  logic          grp_trap64,
  input  logic          grp_trap32,
  input  logic          rd_trap64,
  input  logic          rd_trap32,
  input  logic          wr_trap64,
  input  logic          wr_trap32,
  input  logic [DW-1:0] wdata,
  output logic          hit,
  output logic [1:0]    outcome,
  output logic [5:0]    syndrome,
  output logic [DW-1:0] rdata
);
  localparam logic [1:0] OC_OK = 2'd0, OC_UNDEF = 2'd1, OC_TRAP64 = 2'd2, OC_TRAP32 = 2'd3;
  typedef enum logic [1:0] {BK_FLAT, BK_SEC, BK_NSEC} bank_e;

  logic [DW-1:0] cp_sec, cp_nsec, cp_flat;
  logic          l3_banked, grp_hit, vm_hit, wr_ok;
  bank_e         bank;

  assign hit = req_valid && enc_cp == 4'hF && enc_op1 == 3'd0 &&
               enc_crn == 4'h5 && enc_crm == 4'h1 && enc_op2 == 3'd1;

  assign l3_banked = lvl3_present && lvl3_is32;
  assign grp_hit   = lvl2_is32 ? grp_trap32 : grp_trap64;
  assign vm_hit    = req_write ? (lvl2_is32 ? wr_trap32 : wr_trap64)
                               : (lvl2_is32 ? rd_trap32 : rd_trap64);

  always_comb begin
    outcome = OC_OK;
    bank    = BK_FLAT;
    if (hit) begin
      unique case (cur_lvl)
        2'd0: outcome = OC_UNDEF;
        2'd1: begin
          if (lvl2_en && (grp_hit || vm_hit))
            outcome = lvl2_is32 ? OC_TRAP32 : OC_TRAP64;
          else if (l3_banked)
            bank = ns_bit ? BK_NSEC : BK_SEC;
        end
        2'd2: bank = l3_banked ? BK_NSEC : BK_FLAT;
        default: bank = ns_bit ? BK_NSEC : BK_SEC;
      endcase
    end
  end

  assign syndrome = outcome[1] ? TRAP_EC : 6'd0;
  assign wr_ok    = hit && req_write && outcome == OC_OK;

  always_comb begin
    rdata = '0;
    if (hit && !req_write && outcome == OC_OK) begin
      unique case (bank)
        BK_SEC:  rdata = cp_sec;
        BK_NSEC: rdata = cp_nsec;
        default: rdata = cp_flat;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_sec  <= RST_VAL;
      cp_nsec <= RST_VAL;
      cp_flat <= RST_VAL;
    end else if (wr_ok) begin
      if (bank == BK_SEC)  cp_sec  <= wdata;
      if (bank == BK_NSEC) cp_nsec <= wdata;
      if (bank == BK_FLAT) cp_flat <= wdata;
    end
  end

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (outcome == OC_OK && rdata == '0)); // R1
  AST_MISS_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(cp_sec) && $stable(cp_nsec) && $stable(cp_flat))); // R1
  AST_LVL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cur_lvl == 2'd0) |-> outcome == OC_UNDEF); // R2
  AST_TRAP_SYND: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome == OC_TRAP64 || outcome == OC_TRAP32) |-> syndrome == TRAP_EC); // R3
  AST_NO_L2_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !lvl2_en) |-> !(outcome == OC_TRAP64 || outcome == OC_TRAP32)); // R5
  AST_FAULT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_write && outcome != OC_OK) |=> ($stable(cp_sec) && $stable(cp_nsec) && $stable(cp_flat))); // R9
  AST_FAULT_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    outcome != OC_OK |-> rdata == '0); // R9
  AST_SYND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome == OC_OK || outcome == OC_UNDEF) |-> syndrome == 6'd0); // R9
endmodule

// File: tb/tb_auxfault_bank_reg.sv
module tb_auxfault_bank_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid, req_write, lvl2_en, lvl2_is32, lvl3_present, lvl3_is32, ns_bit;
  logic grp_trap64, grp_trap32, rd_trap64, rd_trap32, wr_trap64, wr_trap32;
  logic [3:0] enc_cp, enc_crn, enc_crm;
  logic [2:0] enc_op1, enc_op2;
  logic [1:0] cur_lvl, outcome;
  logic [5:0] syndrome;
  logic [31:0] wdata, rdata;
  logic hit;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mdl [3];
  bit done = 0;

  always #5 clk = ~clk;

  auxfault_bank_reg dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit enc_ok();
    return req_valid && enc_cp == 4'hF && enc_op1 == 0 && enc_crn == 4'h5 && enc_crm == 4'h1 && enc_op2 == 1;
  endfunction

  // expected outcome and bank (0 flat, 1 secure, 2 non-secure)
  function automatic void model(output logic [1:0] oc, output int bk, output string tag);
    bit l3b = lvl3_present && lvl3_is32;
    bit g = lvl2_is32 ? grp_trap32 : grp_trap64;
    bit v = req_write ? (lvl2_is32 ? wr_trap32 : wr_trap64) : (lvl2_is32 ? rd_trap32 : rd_trap64);
    oc = 0; bk = 0;
    if (!enc_ok()) begin tag = "R1"; return; end
    case (cur_lvl)
      0: begin oc = 1; tag = "R2"; end
      1: begin
        if (lvl2_en && g) begin oc = lvl2_is32 ? 3 : 2; tag = "R3"; end
        else if (lvl2_en && v) begin oc = lvl2_is32 ? 3 : 2; tag = "R4"; end
        else begin
          bk = l3b ? (ns_bit ? 2 : 1) : 0;
          tag = lvl2_en ? "R6" : "R5";
        end
      end
      2: begin bk = l3b ? 2 : 0; tag = "R7"; end
      default: begin bk = ns_bit ? 2 : 1; tag = "R8"; end
    endcase
  endfunction

  task automatic step();
    logic [1:0] oc; int bk; string tag;
    model(oc, bk, tag);
    #2;
    chk({tag, " hit"}, {31'd0, hit}, {31'd0, enc_ok()});
    chk({tag, " outcome"}, {30'd0, outcome}, {30'd0, oc});
    chk({tag, " syndrome"}, {26'd0, syndrome}, oc[1] ? 32'h3 : 32'h0);
    chk({tag, " rdata"}, rdata, (enc_ok() && !req_write && oc == 0) ? mdl[bk] : 32'h0);
    @(posedge clk);
    if (enc_ok() && req_write && oc == 0) mdl[bk] = wdata;
    @(negedge clk);
  endtask

  task automatic quiet();
    req_valid = 1; req_write = 0; enc_cp = 4'hF; enc_op1 = 0; enc_crn = 4'h5; enc_crm = 4'h1; enc_op2 = 1;
    cur_lvl = 3; lvl2_en = 0; lvl2_is32 = 0; lvl3_present = 1; lvl3_is32 = 1; ns_bit = 0;
    {grp_trap64, grp_trap32, rd_trap64, rd_trap32, wr_trap64, wr_trap32} = '0;
    wdata = 0;
  endtask

  task automatic readback_all(); // R9 R10: observe all three copies
    quiet(); cur_lvl = 3; ns_bit = 0; step();
    ns_bit = 1; step();
    cur_lvl = 2; lvl3_present = 0; step();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mdl[0] = 0; mdl[1] = 0; mdl[2] = 0;
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    readback_all(); // R10 reset values
    // R10 write each copy
    quiet(); req_write = 1; cur_lvl = 3; ns_bit = 0; wdata = 32'hA5A5_0001; step();
    ns_bit = 1; wdata = 32'h5A5A_0002; step();
    cur_lvl = 2; lvl3_present = 0; ns_bit = 1; wdata = 32'hFFFF_0003; step();
    readback_all();
    // R2 level 0 write
    quiet(); req_write = 1; cur_lvl = 0; wdata = 32'hDEAD_BEEF; step(); readback_all();
    // R4 read trap bit during write ignored; write trap bit in wrong mode ignored
    quiet(); req_write = 1; cur_lvl = 1; lvl2_en = 1; lvl2_is32 = 0; rd_trap64 = 1; wr_trap32 = 1;
    wdata = 32'h1234_5678; step(); readback_all();
    // R4 write trap traps, copies unchanged (R9)
    quiet(); req_write = 1; cur_lvl = 1; lvl2_en = 1; lvl2_is32 = 1; wr_trap32 = 1; wdata = 32'h0BAD_0BAD; step();
    readback_all();
    // R3 group trap, 64-bit mode, read
    quiet(); cur_lvl = 1; lvl2_en = 1; grp_trap64 = 1; step();
    grp_trap64 = 0; grp_trap32 = 1; step(); // wrong-mode copy: no trap
    // R7 level 2 ignores NS
    quiet(); cur_lvl = 2; ns_bit = 0; step();
    // R1 single-field miss write
    quiet(); req_write = 1; cur_lvl = 3; enc_op2 = 3'd0; wdata = 32'h7777_7777; step();
    quiet(); req_write = 1; cur_lvl = 3; enc_crm = 4'h0; wdata = 32'h6666_6666; step();
    readback_all();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      req_valid = ($urandom % 16) != 0;
      req_write = $urandom % 2;
      enc_cp = 4'hF; enc_op1 = 0; enc_crn = 4'h5; enc_crm = 4'h1; enc_op2 = 1;
      if (($urandom % 8) == 0)
        case ($urandom % 5)
          0: enc_cp = $urandom;  1: enc_op1 = $urandom; 2: enc_crn = $urandom;
          3: enc_crm = $urandom; default: enc_op2 = $urandom;
        endcase
      cur_lvl = $urandom; lvl2_en = $urandom; lvl2_is32 = $urandom;
      lvl3_present = $urandom; lvl3_is32 = $urandom; ns_bit = $urandom;
      grp_trap64 = ($urandom % 4) == 0; grp_trap32 = ($urandom % 4) == 0;
      rd_trap64 = ($urandom % 3) == 0; rd_trap32 = ($urandom % 3) == 0;
      wr_trap64 = ($urandom % 3) == 0; wr_trap32 = ($urandom % 3) == 0;
      wdata = $urandom;
      step();
    end
    readback_all();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule